// File: doc/BRIEF.md
# Key Matrix Scan Encoder

This block scans a square matrix of push keys and turns the first closure it finds into a compact key code. A circulating ring register holds exactly one low bit. That low bit drives one row line low at a time and moves to the next row on every clock. Each column sense line idles high through an external pull-up. A closed key joins its column to the active row, so that column reads low.

When any column reads low during scanning, the block stops the ring on the row being driven. It encodes the row position and the lowest low column into a key code, latches the code, and raises a valid strobe for one cycle. The block then waits. Scanning restarts only when two conditions hold together: every column has gone high again, and the release indication is asserted.

The block is meant to run from a slow scan clock, nominally in the 5 kHz range. At that rate each row dwells long enough for the matrix wiring to settle.

Top module: `key_scan_encoder`

## Requirements
- R1: After reset the row drive equals 8'hFE, so only row 0 is low. The key code is 0 and the valid strobe is low.
- R2: While scanning and with all columns high, the low row moves from row i to row i+1 on each clock edge. Row 7 wraps to row 0. Row i is bit i of the row drive.
- R3: Exactly one row drive bit is low at all times.
- R4: A column that reads low while scanning is captured at that clock edge. The key code is {row index, column index}: bits [5:3] hold the row index and bits [2:0] hold the column index. Column c is bit c of the column sense input.
- R5: When several columns read low at once, the lowest-numbered column is encoded.
- R6: The valid strobe is high for exactly one cycle, in the cycle right after the capturing edge. The new key code is present in that same cycle.
- R7: After a capture, the row drive stays on the captured row and the key code holds its value for as long as the block waits.
- R8: The block waits while any column is low, and also while the release indication is low. On the first edge that sees all columns high with the release indication high, scanning resumes. The row advances on the edge after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rstN | input | 1 | Asynchronous reset, active low |
| colSenseN | input | 8 | Column sense lines, low means a closure on the driven row |
| keyReleased | input | 1 | Release indication, high permits scanning to resume |
| rowDriveN | output | 8 | Row drive lines, the single low bit selects the scanned row |
| keyCode | output | 6 | Latched key code {row, column} |
| keyValid | output | 1 | One-cycle strobe marking a newly latched code |

## Verification
The inputs change on the falling edge and the outputs are sampled on the falling edge, so each check sees the state left by exactly one rising edge. After a closure on the active row, the code and the valid strobe appear one edge later, and the strobe clears after the next edge. After a qualified release, the row stays put for one edge and advances on the second. The bench waits for the strobe with a bounded loop. All hold and resume checks are then counted in whole cycles from that point, so each result is sampled at the falling edge where it is due.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  typedef struct packed {
    logic shiftEn;
    logic capture;
  } scan_ctl_t;

  typedef enum logic {ST_SCAN = 1'b0, ST_HOLD = 1'b1} scan_state_t;
endpackage

// File: rtl/keyscan_ctrl.sv
module keyscan_ctrl
  import keyscan_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      anyColLow,
  input  logic      keyReleased,
  output scan_ctl_t ctl,
  output logic      keyValid
);
  scan_state_t state, stateNext;

  always_comb begin
    ctl.shiftEn = (state == ST_SCAN) && !anyColLow;
    ctl.capture = (state == ST_SCAN) && anyColLow;
    stateNext   = state;
    case (state)
      ST_SCAN: if (anyColLow) stateNext = ST_HOLD;
      ST_HOLD: if (!anyColLow && keyReleased) stateNext = ST_SCAN;
      default: stateNext = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_SCAN;
      keyValid <= 1'b0;
    end else begin
      state    <= stateNext;
      keyValid <= ctl.capture;
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |=> !keyValid); // R6
  AST_WAIT_WHILE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && anyColLow) |=> (state == ST_HOLD)); // R8
  AST_WAIT_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !keyReleased) |=> (state == ST_HOLD)); // R8
endmodule

// File: rtl/keyscan_datapath.sv
module keyscan_datapath
  import keyscan_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  scan_ctl_t       ctl,
  input  logic [COLS-1:0] colSenseN,
  output logic [ROWS-1:0] rowDriveN,
  output logic            anyColLow,
  output logic [RW+CW-1:0] keyCode
);
  localparam logic [ROWS-1:0] RingInit = {{(ROWS-1){1'b1}}, 1'b0};

  logic [ROWS-1:0] ringQ;
  logic [RW-1:0]   rowIdx;
  logic [CW-1:0]   colIdx;

  // Lowest-numbered low column wins: scan downward so the last hit is the lowest.
  always_comb begin
    colIdx = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (!colSenseN[i]) colIdx = CW'(i);
    end
  end

  always_comb begin
    rowIdx = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (!ringQ[i]) rowIdx = RW'(i);
    end
  end

  assign anyColLow = ~&colSenseN;
  assign rowDriveN = ringQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ringQ   <= RingInit;
      keyCode <= '0;
    end else begin
      if (ctl.shiftEn) ringQ <= {ringQ[ROWS-2:0], ringQ[ROWS-1]};
      if (ctl.capture) keyCode <= {rowIdx, colIdx};
    end
  end

  AST_SINGLE_LOW_ROW: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~rowDriveN) == 1); // R3
  AST_RING_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> $stable(rowDriveN)); // R7
  AST_CAPTURE_NEEDS_COL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> anyColLow); // R4
endmodule

// File: rtl/key_scan_encoder.sv
module key_scan_encoder
  import keyscan_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int CODE_W = $clog2(ROWS) + $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [COLS-1:0]   colSenseN,
  input  logic              keyReleased,
  output logic [ROWS-1:0]   rowDriveN,
  output logic [CODE_W-1:0] keyCode,
  output logic              keyValid
);
  scan_ctl_t ctl;
  logic      anyColLow;

  keyscan_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .anyColLow(anyColLow),
    .keyReleased(keyReleased), .ctl(ctl), .keyValid(keyValid)
  );

  keyscan_datapath #(.ROWS(ROWS), .COLS(COLS)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .colSenseN(colSenseN),
    .rowDriveN(rowDriveN), .anyColLow(anyColLow), .keyCode(keyCode)
  );
endmodule

// File: tb/test_key_scan_encoder.sv
`timescale 1ns/1ps
module test_key_scan_encoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] colSenseN;
  logic       keyReleased = 1'b1;
  logic [7:0] rowDriveN;
  logic [5:0] keyCode;
  logic       keyValid;
  logic [63:0] pressMat = '0;  // bit r*8+c = key at row r, column c closed
  int checkCnt = 0;
  int failCnt = 0;

  always #2 clk = ~clk;

  key_scan_encoder i_key_scan_encoder (
    .clk(clk), .rstN(rstN), .colSenseN(colSenseN), .keyReleased(keyReleased),
    .rowDriveN(rowDriveN), .keyCode(keyCode), .keyValid(keyValid)
  );

  always_comb begin
    for (int c = 0; c < 8; c++) begin
      colSenseN[c] = 1'b1;
      for (int r = 0; r < 8; r++)
        if (pressMat[r*8+c] && !rowDriveN[r]) colSenseN[c] = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rowPat(input int r);
    return ~(8'h01 << r);
  endfunction

  task automatic t_reset();
    check(rowDriveN == 8'hFE, "R1 row drive", rowDriveN, 8'hFE);
    check(keyCode == 6'd0, "R1 key code", keyCode, 0);
    check(keyValid == 1'b0, "R1 valid", keyValid, 0);
  endtask

  task automatic t_walk(input int startRow, input int steps);
    int r = startRow;
    for (int k = 0; k < steps; k++) begin
      @(negedge clk);
      r = (r + 1) % 8;
      check(rowDriveN == rowPat(r), "R2 advance/wrap", rowDriveN, rowPat(r));
      check($countones(~rowDriveN) == 1, "R3 single low row", rowDriveN, 1);
    end
  endtask

  task automatic t_press(input logic [63:0] keys, input int expRow, input int expCol);
    int waitCnt = 0;
    pressMat = keys;
    while (!keyValid && waitCnt < 20) begin
      @(negedge clk);
      waitCnt++;
    end
    check(keyValid == 1'b1, "R6 strobe seen", keyValid, 1);
    check(keyCode == 6'((expRow << 3) | expCol), "R4/R5 key code", keyCode, (expRow << 3) | expCol);
    check(rowDriveN == rowPat(expRow), "R7 row stopped", rowDriveN, rowPat(expRow));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(keyValid == 1'b0, "R6 strobe single cycle", keyValid, 0);
      check(rowDriveN == rowPat(expRow), "R8 wait while key held", rowDriveN, rowPat(expRow));
      check(keyCode == 6'((expRow << 3) | expCol), "R7 code held", keyCode, (expRow << 3) | expCol);
    end
    pressMat = '0;
    keyReleased = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(rowDriveN == rowPat(expRow), "R8 wait for release", rowDriveN, rowPat(expRow));
    end
    keyReleased = 1'b1;
    @(negedge clk);
    check(rowDriveN == rowPat(expRow), "R8 resume edge", rowDriveN, rowPat(expRow));
    @(negedge clk);
    check(rowDriveN == rowPat((expRow + 1) % 8), "R8 advance after resume",
          rowDriveN, rowPat((expRow + 1) % 8));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_walk(0, 10);                        // R2 including the 7->0 wrap
    t_press(64'h1 << (2*8+3), 2, 3);      // R4 single key
    t_press((64'h1 << (5*8+5)) | (64'h1 << (5*8+2)), 5, 2);  // R5 two columns
    t_press(64'h1 << (7*8+7), 7, 7);      // R4 last row, last column
    t_press((64'h1 << (1*8+4)) | (64'h1 << (6*8+4)), 1, 4);  // row reached first wins
    t_press(64'h1 << (0*8+0), 0, 0);      // R4 row 0 column 0 after full wrap
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule